// File: doc/BRIEF.md
# Sector ECC Syndrome Classifier and Bit Fixer

This block closes the check on one flash sector protected by a 24-bit Hamming-style code. When `start` is pulsed it takes the 32-bit word from the parity engine and the three code bytes that were read back from the spare area. It then does four things:

- Packs the engine word into 24 bits and inverts it, so that an erased sector checks clean.
- XORs the packed value with the stored bytes to form the syndrome.
- Sorts the syndrome into exactly one of four outcomes: clean, a single fixable data bit, damage confined to the code bytes, or fatal.
- For a fixable bit, reports the byte position and a one-hot bit mask.

The packed and inverted code is also offered as a three-byte value, ready to be written into the spare area.

After the check, the sector can be streamed through the byte port. The block counts bytes from zero. It flips the reported bit in the byte whose count equals the reported position. Every other byte passes unchanged, one cycle later.

Top module: `sector_ecc_fix`

## Requirements
- R1: One cycle after `start`, `calc_ecc` equals the bitwise inverse of {raw_ecc[27:16], raw_ecc[11:0]}. The lowest byte of the code is in bits 7:0, the middle byte in 15:8 and the top byte in 23:16. Raw bits 31:28 and 15:12 have no effect.
- R2: `done` is high for exactly the one cycle after a `start`. While `done` is high, exactly one of `ok_o`, `fixed_o`, `ecc_only_o`, `fatal_o` is set.
- R3: The syndrome is calc ^ {st_b2, st_b1, st_b0}. A zero syndrome gives `ok_o`.
- R4: A syndrome is fixable when its bits 23:12 XOR its bits 11:0 equal 0xFFF. In that case `fixed_o` is set, `err_byte` = syndrome[23:15], and `err_mask` = 1 << syndrome[14:12].
- R5: A syndrome that passes the test in R4 but has a byte position not below SECTOR_BYTES gives `fatal_o`.
- R6: A nonzero syndrome that fails the test in R4 and has exactly one bit set gives `ecc_only_o`. In that case `err_mask` is zero and streamed data is unchanged.
- R7: Every other nonzero syndrome gives `fatal_o`.
- R8: `err_mask` and `err_byte` are zero unless `fixed_o` is set.
- R9: Each `din_valid` beat gives `dout_valid` one cycle later. The byte count restarts at zero on `start`. When `fixed_o` is set, `dout` is `din` XOR `err_mask` on the beat whose count equals `err_byte`; otherwise `dout` equals `din`.
- R10: The status outputs, `err_byte`, `err_mask` and `calc_ecc` hold their values until the next `start`.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a check with the current code inputs |
| raw_ecc | input | 32 | Word from the parity engine |
| st_b0 | input | 8 | Stored code byte, lowest |
| st_b1 | input | 8 | Stored code byte, middle |
| st_b2 | input | 8 | Stored code byte, highest |
| din_valid | input | 1 | Sector byte valid |
| din | input | 8 | Sector byte in |
| done | output | 1 | Check finished, one-cycle pulse |
| ok_o | output | 1 | Clean sector |
| fixed_o | output | 1 | Single fixable data-bit error |
| ecc_only_o | output | 1 | Error confined to the code bytes |
| fatal_o | output | 1 | Uncorrectable |
| err_byte | output | 9 | Byte position of the fixable bit |
| err_mask | output | 8 | One-hot mask of the fixable bit |
| calc_ecc | output | 24 | Packed, inverted code |
| dout_valid | output | 1 | Corrected byte valid |
| dout | output | 8 | Corrected byte out |

## Verification
The case hardest to reach from the ports is a fixable syndrome whose byte position lies beyond the sector. With the default 512-byte sector, a 9-bit position can never be out of range. The bench therefore drives a second instance with a 256-byte sector from the same stimulus, and derives its expected outcome from the reported position. Fixable syndromes are built in the bench by placing a position and bit number in the top half and its complement in the bottom half. The bench then XORs that syndrome onto the packed code to make the stored bytes, and checks the streamed correction at the first and last byte positions as well as in the middle of the sector.

// File: rtl/sector_ecc_fix.sv
module sector_ecc_fix #(
  parameter int SECTOR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] raw_ecc,
  input  logic [7:0]  st_b0,
  input  logic [7:0]  st_b1,
  input  logic [7:0]  st_b2,
  input  logic        din_valid,
  input  logic [7:0]  din,
  output logic        done,
  output logic        ok_o,
  output logic        fixed_o,
  output logic        ecc_only_o,
  output logic        fatal_o,
  output logic [8:0]  err_byte,
  output logic [7:0]  err_mask,
  output logic [23:0] calc_ecc,
  output logic        dout_valid,
  output logic [7:0]  dout
);

  localparam int CW = $clog2(SECTOR_BYTES) + 1;

  logic [23:0] packed_w, syn;
  logic        halves_cmp, in_range, one_bit, nz;
  logic [8:0]  idx;
  logic [2:0]  bitn;
  logic [CW-1:0] cnt;
  logic        hit;

  assign packed_w   = ~{raw_ecc[27:16], raw_ecc[11:0]};
  assign syn        = packed_w ^ {st_b2, st_b1, st_b0};
  assign nz         = |syn;
  assign halves_cmp = (syn[23:12] ^ syn[11:0]) == 12'hFFF;
  assign idx        = syn[23:15];
  assign bitn       = syn[14:12];
  assign in_range   = 32'(idx) < SECTOR_BYTES;
  assign one_bit    = nz && ((syn & (syn - 24'd1)) == 24'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      ok_o       <= 1'b0;
      fixed_o    <= 1'b0;
      ecc_only_o <= 1'b0;
      fatal_o    <= 1'b0;
      err_byte   <= '0;
      err_mask   <= '0;
      calc_ecc   <= '0;
    end else begin
      done <= start;
      if (start) begin
        calc_ecc   <= packed_w;
        ok_o       <= !nz;
        fixed_o    <= nz && halves_cmp && in_range;
        ecc_only_o <= nz && !halves_cmp && one_bit;
        fatal_o    <= nz && ((halves_cmp && !in_range) || (!halves_cmp && !one_bit));
        err_byte   <= (nz && halves_cmp && in_range) ? idx : 9'd0;
        err_mask   <= (nz && halves_cmp && in_range) ? (8'd1 << bitn) : 8'd0;
      end
    end
  end

  assign hit = fixed_o && (32'(cnt) == 32'(err_byte));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      dout_valid <= 1'b0;
      dout       <= '0;
    end else begin
      dout_valid <= din_valid;
      if (start)
        cnt <= '0;
      else if (din_valid)
        cnt <= cnt + 1'b1;
      if (din_valid)
        dout <= din ^ (hit ? err_mask : 8'd0);
    end
  end

endmodule

module sector_ecc_fix_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [31:0] raw_ecc,
  input logic        din_valid,
  input logic [7:0]  din,
  input logic        done,
  input logic        ok_o,
  input logic        fixed_o,
  input logic        ecc_only_o,
  input logic        fatal_o,
  input logic [8:0]  err_byte,
  input logic [7:0]  err_mask,
  input logic [23:0] calc_ecc,
  input logic        dout_valid,
  input logic [7:0]  dout
);
  a_r1_pack: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> calc_ecc == ~{$past(raw_ecc[27:16]), $past(raw_ecc[11:0])});
  a_r2_done: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({ok_o, fixed_o, ecc_only_o, fatal_o}) == 1);
  a_r8_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !fixed_o |-> (err_mask == 8'd0 && err_byte == 9'd0));
  a_r4_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_o |-> $onehot(err_mask));
  a_r9_valid: assert property (@(posedge clk) disable iff (!rst_n)
    din_valid |=> dout_valid);
  a_r9_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid && !fixed_o && !start) |=> dout == $past(din));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable({ok_o, fixed_o, ecc_only_o, fatal_o, err_byte, err_mask, calc_ecc}));
endmodule

bind sector_ecc_fix sector_ecc_fix_chk u_chk (.*);

// File: tb/test_sector_ecc_fix.sv
module test_sector_ecc_fix;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, din_valid = 1'b0;
  logic [31:0] raw_ecc = '0;
  logic [7:0]  st_b0 = '0, st_b1 = '0, st_b2 = '0, din = '0;
  logic done, ok_o, fixed_o, ecc_only_o, fatal_o, dout_valid;
  logic [8:0] err_byte;  logic [7:0] err_mask, dout;  logic [23:0] calc_ecc;
  logic s_done, s_ok, s_fix, s_eo, s_fat, s_dv;
  logic [8:0] s_byte;  logic [7:0] s_mask, s_dout;  logic [23:0] s_calc;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  sector_ecc_fix i_sector_ecc_fix (.clk, .rst_n, .start, .raw_ecc, .st_b0, .st_b1, .st_b2,
    .din_valid, .din, .done, .ok_o, .fixed_o, .ecc_only_o, .fatal_o, .err_byte, .err_mask,
    .calc_ecc, .dout_valid, .dout);

  sector_ecc_fix #(.SECTOR_BYTES(256)) i_small (.clk, .rst_n, .start, .raw_ecc, .st_b0, .st_b1,
    .st_b2, .din_valid, .din, .done(s_done), .ok_o(s_ok), .fixed_o(s_fix), .ecc_only_o(s_eo),
    .fatal_o(s_fat), .err_byte(s_byte), .err_mask(s_mask), .calc_ecc(s_calc),
    .dout_valid(s_dv), .dout(s_dout));

  // fields: raw[69:38] syndrome[37:14] class[13:12] (0 ok,1 fix,2 ecc,3 fatal) byte[11:3] bit[2:0]
  localparam int NV = 10;
  localparam logic [69:0] VEC [NV] = '{
    {32'h0000_0000, 24'h000000, 2'd0, 9'd0,   3'd0},
    {32'hF123_F456, 24'h000000, 2'd0, 9'd0,   3'd0},
    {32'h0ABC_0DEF, 24'h02BFD4, 2'd1, 9'd5,   3'd3},
    {32'h1234_5678, 24'hFFF000, 2'd1, 9'd511, 3'd7},
    {32'h8765_4321, 24'h000FFF, 2'd1, 9'd0,   3'd0},
    {32'h5555_AAAA, 24'h96269D, 2'd1, 9'd300, 3'd2},
    {32'h0F0F_0F0F, 24'h000001, 2'd2, 9'd0,   3'd0},
    {32'hFFFF_FFFF, 24'h800000, 2'd2, 9'd0,   3'd0},
    {32'h3C3C_3C3C, 24'h000003, 2'd3, 9'd0,   3'd0},
    {32'h7777_1111, 24'hFFFFFF, 2'd3, 9'd0,   3'd0}
  };

  task automatic chk(input bit good, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] pack_inv(input logic [31:0] r);
    return ~{r[27:16], r[11:0]};
  endfunction

  task automatic run_check(input logic [31:0] r, input logic [23:0] syn);
    logic [23:0] st;
    st = pack_inv(r) ^ syn;
    @(negedge clk);
    raw_ecc = r; st_b0 = st[7:0]; st_b1 = st[15:8]; st_b2 = st[23:16]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic stream_check(input bit fix, input logic [8:0] pos, input logic [7:0] m, input string req);
    for (int i = 0; i < 512; i++) begin
      logic [7:0] e;
      din_valid = 1'b1; din = 8'(i) ^ 8'h5A;
      e = din ^ ((fix && i == int'(pos)) ? m : 8'd0);
      @(negedge clk);
      chk(dout_valid && dout == e, req, {23'd0, dout_valid, dout}, {24'd1, e});
    end
    din_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({done, ok_o, fixed_o, ecc_only_o, fatal_o, dout_valid} == 0 && calc_ecc == 0 && err_mask == 0,
        "R11 reset", {26'd0, done, ok_o, fixed_o, ecc_only_o, fatal_o, dout_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] r; logic [23:0] sy; logic [1:0] c; logic [8:0] b; logic [2:0] bt;
      logic [3:0] ef, sf; logic [7:0] em;
      {r, sy, c, b, bt} = VEC[v];
      run_check(r, sy);
      ef = 4'b1000 >> c;
      em = (c == 2'd1) ? (8'd1 << bt) : 8'd0;
      sf = (c == 2'd1 && b >= 9'd256) ? 4'b0001 : ef;
      chk(done, "R2 done pulse", {31'd0, done}, 1);
      chk(calc_ecc == pack_inv(r), "R1 packed code", {8'd0, calc_ecc}, {8'd0, pack_inv(r)});
      chk({ok_o, fixed_o, ecc_only_o, fatal_o} == ef, "R3/R4/R6/R7 outcome",
          {28'd0, ok_o, fixed_o, ecc_only_o, fatal_o}, {28'd0, ef});
      chk(err_mask == em && err_byte == ((c == 2'd1) ? b : 9'd0), "R4 R8 position and mask",
          {15'd0, err_byte, err_mask}, {15'd0, (c == 2'd1) ? b : 9'd0, em});
      chk({s_ok, s_fix, s_eo, s_fat} == sf, "R5 small-sector outcome",
          {28'd0, s_ok, s_fix, s_eo, s_fat}, {28'd0, sf});
      @(negedge clk);
      chk(!done, "R2 done one cycle", {31'd0, done}, 0);
      if (v == 2) stream_check(1'b1, 9'd5, 8'h08, "R9 fix mid sector");
      if (v == 3) stream_check(1'b1, 9'd511, 8'h80, "R9 fix last byte");
      if (v == 4) stream_check(1'b1, 9'd0, 8'h01, "R9 fix first byte");
      if (v == 6) stream_check(1'b0, 9'd0, 8'h00, "R6 ecc-only leaves data");
      if (v == 8) stream_check(1'b0, 9'd0, 8'h00, "R9 fatal passes through");
    end

    // R10 hold: change inputs without start
    run_check(32'h0ABC_0DEF, 24'h02BFD4);
    @(negedge clk);
    raw_ecc = 32'hDEAD_BEEF; st_b0 = 8'h11; st_b1 = 8'h22; st_b2 = 8'h33;
    repeat (4) @(negedge clk);
    chk(fixed_o && !ok_o && err_byte == 9'd5 && err_mask == 8'h08 && calc_ecc == pack_inv(32'h0ABC_0DEF),
        "R10 hold", {15'd0, err_byte, err_mask}, {15'd0, 9'd5, 8'h08});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule